// File: doc/BRIEF.md
# Link Power and Wake Controller

This block sits between a physical-layer core and its link-layer controller and runs on the 49.152 MHz system clock. While hardware reset is held, it reads the strap levels that set the default bus-manager contender bit and the three-bit power-class field, and it keeps the last values it read for the self-ID logic once reset is released. The shared contender/link-on pin is an input during reset and an output after it.

The link power status input passes through a synchronizer and an asymmetric filter. A single high sample marks the link as powered up at once. The link is marked as powered down only after a long, unbroken run of low samples. While the link is down, the PHY-link interface enable is low and a repeater-only indication is high, so the node keeps forwarding network traffic.

When a link-on packet indication arrives while the link is down, the block drives a square wave on the link-on output. It keeps the wave running until the link reports power. At that point the wave stops and the interface enable rises.

Top module: `link_power_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `contender_o` takes the level of `strap_cont_i` at that edge (1 = contender). After reset is released it holds the last value captured, whatever the strap pin does.
- R2: While `rst_n` is sampled low at a clock edge, `pwr_class_o` takes `strap_pwr_i` at that edge. After reset it holds the last value captured.
- R3: `pin_drive_o` (1 = the shared pin is driven as the link-on output) is 0 during reset and is 1 from the first clock edge at which `rst_n` is sampled high.
- R4: A `linkon_pkt_i` pulse sampled at edge E while the link is down starts a wave with a period of 8 cycles. `linkon_o` is high in the 4 cycles that follow edges E through E+3, low for the next 4 cycles, and the pattern then repeats.
- R5: `linkon_o` is 0 in every cycle in which `link_up_o` is 1.
- R6: A high level on `lps_i` that is sampled at edge K makes `link_up_o` 1 after edge K+2. One sample is enough.
- R7: `link_up_o` falls only after LOW_CYC (default 1229) consecutive low synchronized samples. Any high sample restarts that count, and a run shorter than LOW_CYC leaves the link up.
- R8: `if_en_o` equals `link_up_o`, and `repeat_only_o` is its complement. Both are also valid during reset, where the link counts as down.
- R9: When the link comes up, the wave is cleared. After a later power-down, `linkon_o` stays low until a new `linkon_pkt_i` arrives.
- R10: A `linkon_pkt_i` pulse that arrives while `link_up_o` is 1 is ignored, and no wave follows.
- R11: A `linkon_pkt_i` pulse that arrives during an active wave does not restart the phase of that wave.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_cont_i | input | 1 | Level on the shared pin while it acts as an input |
| strap_pwr_i | input | 3 | Power-class strap pins |
| lps_i | input | 1 | Raw link power status from the link layer |
| linkon_pkt_i | input | 1 | One-cycle pulse: a link-on packet was received |
| contender_o | output | 1 | Captured default contender bit |
| pwr_class_o | output | 3 | Captured default power class |
| pin_drive_o | output | 1 | Output enable for the shared pin |
| linkon_o | output | 1 | Link-on square wave |
| link_up_o | output | 1 | Filtered link-powered indication |
| if_en_o | output | 1 | PHY-link interface enable |
| repeat_only_o | output | 1 | Repeater-only operation indication |

## Verification
The bench targets several corner cases. It changes the straps between cycles of reset and again after release: a design that latched on the first or the wrong edge would report a stale contender bit or power class. It sends a low run that stops ten cycles short of the threshold and is broken by a single high sample. A design that failed to clear its count would drop the link early, and one that needed more than one high sample would be late in raising it. It also sends link-on requests at three awkward moments: while the link is up (a wrong design would start a wave), in the middle of an active wave (a wrong design would restart the phase), and right after a power-down that follows an earlier wave (a wrong design would resume the old wave instead of staying quiet).

// File: rtl/lpc_pkg.sv
// Shared types and constants for the link power and wake controller.
package lpc_pkg;
    localparam int PWR_CLASS_W = 3;
    typedef logic [PWR_CLASS_W-1:0] pwr_class_t;
endpackage

// File: rtl/lpc_strap_capture.sv
// Captures the contender and power-class straps on every clock edge at which
// reset is held, and holds them afterwards. Also produces the output enable
// for the shared pin. Assumes the straps are static around the release of reset.
module lpc_strap_capture
    import lpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cont_pin,
    input  pwr_class_t class_pins,
    output logic       contender,
    output pwr_class_t pwr_class,
    output logic       pin_drive
);
    // Strap registers: load while reset is held, freeze otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            contender <= cont_pin;
            pwr_class <= class_pins;
        end
    end

    // Pin direction: input during reset, output from the first edge after it.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_drive <= 1'b0;
        else        pin_drive <= 1'b1;
    end
endmodule

// File: rtl/lpc_lps_filter.sv
// Synchronizes the link power status and filters it asymmetrically. One high
// sample marks the link as up, and LOW_CYC consecutive low samples mark it as
// down. Assumes SYNC_STAGES >= 2 and LOW_CYC >= 1.
module lpc_lps_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYC     = 1229
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_raw,
    output logic link_up
);
    localparam int CNT_W = $clog2(LOW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOW_CYC);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt;
    logic [CNT_W-1:0]       low_nxt;

    // Synchronizer chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= lps_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Next value of the saturating count of low samples.
    always_comb begin
        low_nxt = (low_cnt == CNT_MAX) ? CNT_MAX : low_cnt + 1'b1;
    end

    // Filter state: rise on any high sample, fall when the low count saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            link_up <= 1'b0;
        end else if (sync_q[SYNC_STAGES-1]) begin
            low_cnt <= '0;
            link_up <= 1'b1;
        end else begin
            low_cnt <= low_nxt;
            if (low_nxt == CNT_MAX) link_up <= 1'b0;
        end
    end
endmodule

// File: rtl/lpc_wake_gen.sv
// Link-on wave generator. A request that arrives while the link is down starts
// a square wave, high for the first half of WAVE_PERIOD cycles. The wave is
// cleared once the link is up. Assumes WAVE_PERIOD is a power of two, >= 2.
module lpc_wake_gen #(
    parameter int WAVE_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic link_up,
    output logic linkon
);
    localparam int PH_W = $clog2(WAVE_PERIOD);

    logic            wake_q;
    logic [PH_W-1:0] phase_q;

    // Wake state and phase counter; the link-up state has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_q  <= 1'b0;
            phase_q <= '0;
        end else if (link_up) begin
            wake_q  <= 1'b0;
            phase_q <= '0;
        end else if (req && !wake_q) begin
            wake_q  <= 1'b1;
            phase_q <= '0;
        end else if (wake_q) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Output: high in the first half period, forced low while the link is up.
    always_comb begin
        linkon = wake_q && !link_up && !phase_q[PH_W-1];
    end
endmodule

// File: rtl/link_power_ctrl.sv
// Top of the link power and wake controller. Joins the strap capture, the
// status filter and the wake generator. Assumes a single clock domain, with
// lps_i arriving asynchronously.
module link_power_ctrl
    import lpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_CYC     = 1229,
    parameter int WAVE_PERIOD = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strap_cont_i,
    input  logic [PWR_CLASS_W-1:0] strap_pwr_i,
    input  logic                   lps_i,
    input  logic                   linkon_pkt_i,
    output logic                   contender_o,
    output logic [PWR_CLASS_W-1:0] pwr_class_o,
    output logic                   pin_drive_o,
    output logic                   linkon_o,
    output logic                   link_up_o,
    output logic                   if_en_o,
    output logic                   repeat_only_o
);
    logic link_up;

    lpc_strap_capture u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cont_pin   (strap_cont_i),
        .class_pins (strap_pwr_i),
        .contender  (contender_o),
        .pwr_class  (pwr_class_o),
        .pin_drive  (pin_drive_o)
    );

    lpc_lps_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .LOW_CYC     (LOW_CYC)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .lps_raw (lps_i),
        .link_up (link_up)
    );

    lpc_wake_gen #(
        .WAVE_PERIOD (WAVE_PERIOD)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (linkon_pkt_i),
        .link_up (link_up),
        .linkon  (linkon_o)
    );

    // Interface gating from the filtered link state.
    always_comb begin
        link_up_o     = link_up;
        if_en_o       = link_up;
        repeat_only_o = !link_up;
    end
endmodule

// File: rtl/lpc_checker.sv
// Temporal checks on the ports of link_power_ctrl, attached with bind.
module lpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       strap_cont_i,
    input logic [2:0] strap_pwr_i,
    input logic       lps_i,
    input logic       linkon_pkt_i,
    input logic       contender_o,
    input logic [2:0] pwr_class_o,
    input logic       pin_drive_o,
    input logic       linkon_o,
    input logic       link_up_o,
    input logic       if_en_o,
    input logic       repeat_only_o
);
    p_hold_contender_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(contender_o));

    p_hold_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(pwr_class_o));

    p_pin_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_drive_o);

    p_wave_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(linkon_o) |=> (linkon_o || link_up_o));

    p_quiet_when_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        link_up_o |-> !linkon_o);

    p_fall_needs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up_o) |-> !$past(lps_i, 3));

    p_gating_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en_o == link_up_o) && (repeat_only_o != if_en_o));

    p_ignore_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_o && linkon_pkt_i) |=> !linkon_o);

    // Straps are read only in the reset branch; this keeps the inputs in use.
    p_strap_known_r1: assert property (@(posedge clk)
        !rst_n |-> !$isunknown({strap_cont_i, strap_pwr_i}));
endmodule

bind link_power_ctrl lpc_checker u_lpc_checker (.*);

// File: tb/link_power_ctrl_tb_top.sv
// Bench: a behavioural reference model that is compared with the design on
// every clock, plus directed checks on the wave shape.
module link_power_ctrl_tb_top;
    localparam int CLK_P   = 20;
    localparam int LOW_CYC = 1229;
    localparam int PERIOD  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_cont_i = 1'b0;
    logic [2:0] strap_pwr_i = 3'b000;
    logic       lps_i = 1'b0;
    logic       linkon_pkt_i = 1'b0;
    logic       contender_o, pin_drive_o, linkon_o, link_up_o, if_en_o, repeat_only_o;
    logic [2:0] pwr_class_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    link_power_ctrl #(.SYNC_STAGES(2), .LOW_CYC(LOW_CYC), .WAVE_PERIOD(PERIOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_cont_i(strap_cont_i), .strap_pwr_i(strap_pwr_i),
        .lps_i(lps_i), .linkon_pkt_i(linkon_pkt_i), .contender_o(contender_o),
        .pwr_class_o(pwr_class_o), .pin_drive_o(pin_drive_o), .linkon_o(linkon_o),
        .link_up_o(link_up_o), .if_en_o(if_en_o), .repeat_only_o(repeat_only_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Reference model state.
    bit m_started = 0;
    int m_cont = 0, m_pwr = 0, m_pin = 0;
    int m_up = 0, m_low = 0, m_wake = 0, m_phase = 0;
    int m_sync[$] = '{0, 0};

    // Model update: behavioural view of every requirement, per edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 1;
            m_cont = strap_cont_i;                     // R1
            m_pwr = strap_pwr_i;                       // R2
            m_pin = 0;                                 // R3
            m_up = 0; m_low = 0; m_wake = 0; m_phase = 0;
            m_sync = '{0, 0};
        end else begin
            int s;
            int old_up;
            old_up = m_up;
            m_pin = 1;
            s = m_sync.pop_front();
            m_sync.push_back(int'(lps_i));
            if (s != 0) begin m_up = 1; m_low = 0; end          // R6
            else begin
                m_low = (m_low < LOW_CYC) ? m_low + 1 : LOW_CYC;
                if (m_low == LOW_CYC) m_up = 0;                 // R7
            end
            if (old_up != 0) begin m_wake = 0; m_phase = 0; end // R9, R10
            else if (linkon_pkt_i && m_wake == 0) begin m_wake = 1; m_phase = 0; end
            else if (m_wake != 0) m_phase = (m_phase + 1) % PERIOD; // R11
        end
    end

    // Per-cycle comparison, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (m_started) begin
            chk("R1 contender", int'(contender_o), m_cont);
            chk("R2 power class", int'(pwr_class_o), m_pwr);
            chk("R3 pin drive", int'(pin_drive_o), m_pin);
            chk("R4 R5 R9 linkon", int'(linkon_o),
                (m_wake != 0 && m_up == 0 && m_phase < PERIOD/2) ? 1 : 0);
            chk("R6 R7 link up", int'(link_up_o), m_up);
            chk("R8 if enable", int'(if_en_o), m_up);
            chk("R8 repeat only", int'(repeat_only_o), 1 - m_up);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        linkon_pkt_i = 1'b1;
        cyc(1);
        linkon_pkt_i = 1'b0;
    endtask

    // Counts the high cycles of linkon_o over n sampled cycles.
    task automatic count_high(input int n, output int highs);
        highs = 0;
        repeat (n) begin
            @(posedge clk); #(CLK_P/4);
            if (linkon_o) highs++;
        end
    endtask

    initial begin
        int h;
        cyc(1);
        strap_cont_i = 1'b0; strap_pwr_i = 3'b010; cyc(2);
        strap_cont_i = 1'b1; strap_pwr_i = 3'b101; cyc(2);
        rst_n = 1'b1;
        strap_cont_i = 1'b0; strap_pwr_i = 3'b011; cyc(3);
        chk("R1 held after reset", int'(contender_o), 1);
        chk("R2 held after reset", int'(pwr_class_o), 5);

        // R4: wave while link down; R11: second request mid-wave.
        pulse_req();
        count_high(8, h);
        chk("R4 highs per period", h, 4);
        cyc(2); pulse_req(); cyc(12);

        // R6 and R9: link comes up and the wave stops.
        lps_i = 1'b1; cyc(10);
        // R10: request while up.
        pulse_req();
        count_high(16, h);
        chk("R10 no wave while up", h, 0);

        // R7: short low run broken by one high sample, then a full run.
        lps_i = 1'b0; cyc(LOW_CYC - 10);
        lps_i = 1'b1; cyc(1);
        lps_i = 1'b0; cyc(LOW_CYC - 5);
        chk("R7 still up after broken run", int'(link_up_o), 1);
        cyc(20);
        chk("R7 down after full run", int'(link_up_o), 0);
        count_high(16, h);
        chk("R9 no wave without new request", h, 0);

        // R6: single-cycle high sample brings the link up during a wave.
        pulse_req(); cyc(5);
        lps_i = 1'b1; cyc(1); lps_i = 1'b0;
        cyc(6);
        chk("R6 up after single sample", int'(link_up_o), 1);

        // R1, R2: capture again in a second reset.
        rst_n = 1'b0; strap_cont_i = 1'b0; strap_pwr_i = 3'b110; cyc(3);
        rst_n = 1'b1; strap_cont_i = 1'b1; cyc(4);
        chk("R1 second capture", int'(contender_o), 0);
        chk("R2 second capture", int'(pwr_class_o), 6);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired at %0t: actual 0 expected 1", $time);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule